// File: doc/BRIEF.md
# Palette RAM host port

This block is the processor-facing side of a 256-entry colour look-up table. A host reaches four registers through a 2-bit register select and separate read and write strobes. The four registers are an address pointer, the palette data port, an extended-register data port and an 8-bit control register. Palette entries hold one 8-bit value for each of red, green and blue. The host moves through an entry one component at a time, and the pointer steps on after the blue component.

The control register sets how the host and the display side see colour data. A precision bit chooses full 8-bit components or 6-bit components. With 6-bit components, the value sits in the low data lines on the host side and in the high bits on the display side. A sleep bit shuts off palette traffic and the display lookup. The pointer, the control register and the extended registers stay reachable while the block sleeps. An enable bit opens a small bank of extended registers, addressed through the same pointer.

The display side supplies an 8-bit pixel index. One clock later it receives the three components of that entry.

Top module: `palette_host_port`

## Requirements
- R1: After reset, the control register reads 0x00 and the address pointer reads 0x00.
- R2: A write with select 2'b11 loads all eight bits into the control register, and a read with select 2'b11 returns them. The layout is bits 7..4 colour-mode code (stored only), bit 3 sleep, bit 2 spare, bit 1 precision (1 = 8-bit, 0 = 6-bit) and bit 0 extended-register enable.
- R3: Select 2'b00 reads and writes the pointer. Palette writes go through select 2'b01 in the order red, green, blue. The whole entry is stored at the pointer on the blue write, and the pointer then adds one, wrapping from 0xFF to 0x00.
- R4: Palette reads through select 2'b01 return red, then green, then blue of the entry at the pointer, and the pointer adds one after blue. Read data appears on `host_rdata` the clock after the read strobe and holds until the next read. A write strobe wins over a read strobe asserted in the same cycle.
- R5: With precision 0, a palette write stores data lines 5..0 as component bits 7..2 and ignores lines 7..6. A palette read then returns component bits 7..2 on lines 5..0, with lines 7..6 at 0.
- R6: The pixel outputs show the entry at `pix_idx` one clock later. With precision 1 they are the stored values. With precision 0 their bits 1..0 are forced to 0.
- R7: While sleep is 1, palette writes do not change the table, and palette reads return 0x00. Neither moves the pointer or the component phase. After wake-up the stored entries are intact.
- R8: While sleep is 1, the control register, the pointer and the extended registers can still be written and read.
- R9: With enable 1, select 2'b10 reaches extended register number `pointer`. There are EXT_NUM registers, reset to 0x00. A pointer value at or beyond EXT_NUM reads 0x00 and ignores writes. Extended accesses do not move the pointer.
- R10: With enable 0, writes through select 2'b10 change no extended register, and reads through it return 0x00.
- R11: While sleep is 1, all three pixel outputs are 0x00 from the next clock on.
- R12: Writing the pointer restarts the component phase at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 00 pointer, 01 palette, 10 extended data, 11 control |
| host_wr | input | 1 | Write strobe, one access per cycle it is high |
| host_rd | input | 1 | Read strobe, one access per cycle it is high |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| pix_idx | input | 8 | Display-side palette index |
| pix_red | output | 8 | Red component of the looked-up entry |
| pix_grn | output | 8 | Green component of the looked-up entry |
| pix_blu | output | 8 | Blue component of the looked-up entry |

## Verification
The assertions take for granted that each strobe cycle is one complete access. A strobe held high for several cycles is counted as several accesses. The assertions also assume the select input is stable in every cycle with a strobe. The stimulus changes all host inputs only at falling edges and raises each strobe for exactly one cycle. It never raises both strobes together and never reads a palette entry that was not written first, so every expected value is defined.

// File: rtl/palette_pkg.sv
package palette_pkg;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'b00,
    SEL_PAL  = 2'b01,
    SEL_EXT  = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int CTL_SLEEP = 3;
  localparam int CTL_WIDE  = 1;
  localparam int CTL_EXT   = 0;

endpackage

// File: rtl/palette_ctrl_regs.sv
module palette_ctrl_regs #(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int EXT_NUM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_ext,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ext_idx,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] ext_rdata
);
  import palette_pkg::*;

  localparam int            EW      = (EXT_NUM > 1) ? $clog2(EXT_NUM) : 1;
  localparam logic [AW-1:0] EXT_LIM = AW'(EXT_NUM);

  logic [DW-1:0]              ctrl_d;
  logic [EXT_NUM-1:0][DW-1:0] ext_q;
  logic                       idx_ok;
  logic                       ext_we;

  assign idx_ok = (ext_idx < EXT_LIM);
  assign ext_we = wr_ext & ctrl_q[CTL_EXT] & idx_ok;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar i = 0; i < EXT_NUM; i++) begin : g_ext
    logic          hit;
    logic [DW-1:0] nxt;
    assign hit = ext_we & (ext_idx[EW-1:0] == EW'(i));
    always_comb begin
      nxt = ext_q[i];
      if (hit) nxt = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_q[i] <= '0;
      else        ext_q[i] <= nxt;
    end
  end

  always_comb begin
    ext_rdata = '0;
    if (idx_ok) ext_rdata = ext_q[ext_idx[EW-1:0]];
  end

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == $past(wdata)); // R2

  AST_EXT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ext && !ctrl_q[CTL_EXT]) |=> $stable(ext_q)); // R10

  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ext && !idx_ok) |=> $stable(ext_q)); // R9

endmodule

// File: rtl/palette_seq.sv
module palette_seq #(
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ptr_wr,
  input  logic [AW-1:0]        ptr_wdata,
  input  logic                 pal_go,
  output logic [AW-1:0]        ptr_q,
  output palette_pkg::phase_e  phase_q
);
  import palette_pkg::*;

  logic [AW-1:0] ptr_d;
  phase_e        phase_d;

  always_comb begin
    ptr_d   = ptr_q;
    phase_d = phase_q;
    if (ptr_wr) begin
      ptr_d   = ptr_wdata;
      phase_d = PH_RED;
    end else if (pal_go) begin
      case (phase_q)
        PH_RED:  phase_d = PH_GRN;
        PH_GRN:  phase_d = PH_BLU;
        default: begin
          phase_d = PH_RED;
          ptr_d   = ptr_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      phase_q <= PH_RED;
    end else begin
      ptr_q   <= ptr_d;
      phase_q <= phase_d;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_go && !ptr_wr && phase_q == PH_BLU) |=> ptr_q == $past(ptr_q) + 1'b1); // R3

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3); // R3

  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> phase_q == PH_RED); // R12

endmodule

// File: rtl/palette_store.sv
module palette_store #(
  parameter int DW      = 8,
  parameter int ENTRIES = 256,
  parameter int AW      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_go,
  input  palette_pkg::phase_e phase,
  input  logic [AW-1:0]       ptr,
  input  logic [DW-1:0]       wdata_c,
  output logic [DW-1:0]       rd_comp,
  input  logic [AW-1:0]       pix_idx,
  input  logic                sleep,
  input  logic                wide,
  output logic [DW-1:0]       pix_r,
  output logic [DW-1:0]       pix_g,
  output logic [DW-1:0]       pix_b
);
  import palette_pkg::*;

  localparam int EDW = 3 * DW;

  logic [EDW-1:0] mem [ENTRIES];
  logic [DW-1:0]  hold_r, hold_g, hold_r_d, hold_g_d;
  logic           mem_we;
  logic [EDW-1:0] host_ent, pix_ent;
  logic [DW-1:0]  pr_d, pg_d, pb_d;
  logic [DW-1:0]  lsb_mask;

  assign mem_we = wr_go & (phase == PH_BLU);

  always_comb begin
    hold_r_d = hold_r;
    hold_g_d = hold_g;
    if (wr_go && phase == PH_RED) hold_r_d = wdata_c;
    if (wr_go && phase == PH_GRN) hold_g_d = wdata_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r <= '0;
      hold_g <= '0;
    end else begin
      hold_r <= hold_r_d;
      hold_g <= hold_g_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= {hold_r, hold_g, wdata_c};
  end

  assign host_ent = mem[ptr];
  always_comb begin
    case (phase)
      PH_RED:  rd_comp = host_ent[3*DW-1:2*DW];
      PH_GRN:  rd_comp = host_ent[2*DW-1:DW];
      default: rd_comp = host_ent[DW-1:0];
    endcase
  end

  assign pix_ent  = mem[pix_idx];
  assign lsb_mask = wide ? {DW{1'b1}} : {{(DW-2){1'b1}}, 2'b00};

  always_comb begin
    if (sleep) begin
      pr_d = '0;
      pg_d = '0;
      pb_d = '0;
    end else begin
      pr_d = pix_ent[3*DW-1:2*DW] & lsb_mask;
      pg_d = pix_ent[2*DW-1:DW]   & lsb_mask;
      pb_d = pix_ent[DW-1:0]      & lsb_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_r <= '0;
      pix_g <= '0;
      pix_b <= '0;
    end else begin
      pix_r <= pr_d;
      pix_g <= pg_d;
      pix_b <= pb_d;
    end
  end

  AST_DAC_SLEEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (pix_r == '0 && pix_g == '0 && pix_b == '0)); // R11

  AST_DAC_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |=> (pix_r[1:0] == 2'b00 && pix_g[1:0] == 2'b00 && pix_b[1:0] == 2'b00)); // R6

endmodule

// File: rtl/palette_host_port.sv
module palette_host_port #(
  parameter int DW      = 8,
  parameter int ENTRIES = 256,
  parameter int EXT_NUM = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 host_sel,
  input  logic                       host_wr,
  input  logic                       host_rd,
  input  logic [DW-1:0]              host_wdata,
  output logic [DW-1:0]              host_rdata,
  input  logic [$clog2(ENTRIES)-1:0] pix_idx,
  output logic [DW-1:0]              pix_red,
  output logic [DW-1:0]              pix_grn,
  output logic [DW-1:0]              pix_blu
);
  import palette_pkg::*;

  localparam int AW = $clog2(ENTRIES);

  sel_e          sel;
  logic          rd_acc;
  logic [DW-1:0] ctrl_q, ext_rdata, rd_comp, wdata_c;
  logic          sleep, wide, ext_en;
  logic          pal_req, pal_go, pal_wr_go, ptr_wr;
  logic [AW-1:0] ptr_q;
  phase_e        phase_q;
  logic [DW-1:0] rd_val, rdata_d;

  assign sel    = sel_e'(host_sel);
  assign rd_acc = host_rd & ~host_wr;
  assign sleep  = ctrl_q[CTL_SLEEP];
  assign wide   = ctrl_q[CTL_WIDE];
  assign ext_en = ctrl_q[CTL_EXT];

  assign pal_req   = (sel == SEL_PAL) & (host_wr | rd_acc);
  assign pal_go    = pal_req & ~sleep;
  assign pal_wr_go = pal_go & host_wr;
  assign ptr_wr    = host_wr & (sel == SEL_PTR);
  assign wdata_c   = wide ? host_wdata : {host_wdata[DW-3:0], 2'b00};

  palette_ctrl_regs #(.DW(DW), .AW(AW), .EXT_NUM(EXT_NUM)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (host_wr & (sel == SEL_CTRL)),
    .wr_ext    (host_wr & (sel == SEL_EXT)),
    .wdata     (host_wdata),
    .ext_idx   (ptr_q),
    .ctrl_q    (ctrl_q),
    .ext_rdata (ext_rdata)
  );

  palette_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (host_wdata[AW-1:0]),
    .pal_go    (pal_go),
    .ptr_q     (ptr_q),
    .phase_q   (phase_q)
  );

  palette_store #(.DW(DW), .ENTRIES(ENTRIES), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (pal_wr_go),
    .phase   (phase_q),
    .ptr     (ptr_q),
    .wdata_c (wdata_c),
    .rd_comp (rd_comp),
    .pix_idx (pix_idx),
    .sleep   (sleep),
    .wide    (wide),
    .pix_r   (pix_red),
    .pix_g   (pix_grn),
    .pix_b   (pix_blu)
  );

  always_comb begin
    case (sel)
      SEL_PTR:  rd_val = DW'(ptr_q);
      SEL_PAL:  rd_val = sleep ? '0 : (wide ? rd_comp : {2'b00, rd_comp[DW-1:2]});
      SEL_EXT:  rd_val = ext_en ? ext_rdata : '0;
      default:  rd_val = ctrl_q;
    endcase
  end

  always_comb begin
    rdata_d = host_rdata;
    if (rd_acc) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= rdata_d;
  end

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_req && sleep) |=> ($stable(ptr_q) && $stable(phase_q))); // R7

  AST_SLEEP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel == SEL_PAL && sleep) |=> host_rdata == '0); // R7

  AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel == SEL_PAL && !wide) |=> host_rdata[DW-1:DW-2] == 2'b00); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(host_rdata)); // R4

  AST_EXT_READ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel == SEL_EXT && !ext_en) |=> host_rdata == '0); // R10

endmodule

// File: tb/palette_host_port_tb.sv
module palette_host_port_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] host_sel;
  logic       host_wr;
  logic       host_rd;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [7:0] pix_idx;
  logic [7:0] pix_red, pix_grn, pix_blu;

  int n_chk  = 0;
  int n_fail = 0;
  logic rd_seen;
  logic finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  palette_host_port u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .pix_idx    (pix_idx),
    .pix_red    (pix_red),
    .pix_grn    (pix_grn),
    .pix_blu    (pix_blu)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    host_sel = s; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pix(input logic [7:0] idx, input logic [7:0] er, input logic [7:0] eg,
                     input logic [7:0] eb, input string tag);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    check(pix_red, er, {tag, " red"});
    check(pix_grn, eg, {tag, " green"});
    check(pix_blu, eb, {tag, " blue"});
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= host_rd;
  end

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL monitor: got %02h expected none (queue empty)", host_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(host_rdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_sel = 2'b00; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 8'h00; pix_idx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'b11, 8'h00, "R1 ctrl reset");
    rd(2'b00, 8'h00, "R1 pointer reset");

    wr(2'b11, 8'hA6);
    rd(2'b11, 8'hA6, "R2 ctrl readback");

    wr(2'b00, 8'h10);
    wr(2'b01, 8'h12); wr(2'b01, 8'h34); wr(2'b01, 8'hFE);
    rd(2'b00, 8'h11, "R3 pointer step");
    wr(2'b00, 8'h10);
    rd(2'b01, 8'h12, "R4 read red");
    rd(2'b01, 8'h34, "R4 read green");
    rd(2'b01, 8'hFE, "R4 read blue");
    rd(2'b00, 8'h11, "R4 pointer step");
    pix(8'h10, 8'h12, 8'h34, 8'hFE, "R6 wide");

    wr(2'b00, 8'hFF);
    wr(2'b01, 8'h01); wr(2'b01, 8'h02); wr(2'b01, 8'h03);
    rd(2'b00, 8'h00, "R3 pointer wrap");
    pix(8'hFF, 8'h01, 8'h02, 8'h03, "R3 wrap entry");

    wr(2'b11, 8'hA4);
    wr(2'b00, 8'h20);
    wr(2'b01, 8'hFF); wr(2'b01, 8'hC5); wr(2'b01, 8'h3F);
    wr(2'b00, 8'h20);
    rd(2'b01, 8'h3F, "R5 narrow red");
    rd(2'b01, 8'h05, "R5 narrow green");
    rd(2'b01, 8'h3F, "R5 narrow blue");
    wr(2'b00, 8'h10);
    rd(2'b01, 8'h04, "R5 narrow of wide red");
    rd(2'b01, 8'h0D, "R5 narrow of wide green");
    rd(2'b01, 8'h3F, "R5 narrow of wide blue");
    pix(8'h20, 8'hFC, 8'h14, 8'hFC, "R6 narrow");
    pix(8'h10, 8'h10, 8'h34, 8'hFC, "R6 narrow mask");

    wr(2'b11, 8'hA6);
    wr(2'b00, 8'h30);
    wr(2'b01, 8'h55);
    wr(2'b00, 8'h30);
    wr(2'b01, 8'h11); wr(2'b01, 8'h22); wr(2'b01, 8'h33);
    rd(2'b00, 8'h31, "R12 pointer after restart");
    pix(8'h30, 8'h11, 8'h22, 8'h33, "R12 phase restart");

    wr(2'b11, 8'hAE);
    rd(2'b11, 8'hAE, "R8 ctrl in sleep");
    wr(2'b00, 8'h10);
    rd(2'b00, 8'h10, "R8 pointer in sleep");
    wr(2'b01, 8'h99); wr(2'b01, 8'h99); wr(2'b01, 8'h99);
    rd(2'b00, 8'h10, "R7 pointer held on write");
    rd(2'b01, 8'h00, "R7 sleep read zero");
    rd(2'b00, 8'h10, "R7 pointer held on read");
    pix(8'h10, 8'h00, 8'h00, 8'h00, "R11 sleep output");
    wr(2'b11, 8'hA6);
    rd(2'b01, 8'h12, "R7 kept red");
    rd(2'b01, 8'h34, "R7 kept green");
    rd(2'b01, 8'hFE, "R7 kept blue");

    wr(2'b00, 8'h01);
    wr(2'b10, 8'h5A);
    wr(2'b11, 8'hA7);
    rd(2'b10, 8'h00, "R10 locked write");
    wr(2'b10, 8'h5A);
    rd(2'b10, 8'h5A, "R9 ext1");
    wr(2'b00, 8'h02);
    wr(2'b10, 8'hC3);
    rd(2'b10, 8'hC3, "R9 ext2");
    rd(2'b00, 8'h02, "R9 pointer unmoved");
    wr(2'b00, 8'h01);
    rd(2'b10, 8'h5A, "R9 ext1 kept");
    wr(2'b00, 8'h07);
    wr(2'b10, 8'h77);
    rd(2'b10, 8'h00, "R9 out of range");
    wr(2'b11, 8'hA6);
    wr(2'b00, 8'h01);
    rd(2'b10, 8'h00, "R10 locked read");
    wr(2'b10, 8'h11);
    wr(2'b11, 8'hAF);
    rd(2'b10, 8'h5A, "R10 locked write kept");
    wr(2'b00, 8'h02);
    rd(2'b10, 8'hC3, "R8 ext in sleep");

    repeat (4) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule